// File: doc/BRIEF.md
# Four-Voice Wavetable Oscillator Mixer

This block is a four-voice phase-accumulator synthesizer. Each voice holds a 24-bit phase and a 24-bit increment in 9.15 fixed point. On every sample strobe, while the block is in wavetable mode, each voice adds its increment to its phase. The nine integer bits of the new phase then index one byte in a 1024-byte table of unsigned 8-bit samples. The two lower voices are tied to the lower 512-byte half of the table and the two upper voices to the upper half. The four samples are summed and divided by four, and the one result goes to both the left and the right output together with a one-cycle valid pulse.

A host reaches the mode and the voice registers through a byte-wide port. A read is combinational on the addressed byte. Each voice register is laid out most significant byte first, and only its low 24 bits are stored. The table has its own simple byte write port. Mode values other than wavetable leave the oscillators frozen.

Top module: `qwo_top`

## Requirements
- R1: After reset, every phase and increment is zero, the mode register is zero, out_valid is low and both sample outputs are zero.
- R2: The mode register sits at address 0x01. Its bits [1:0] are stored, and bits [7:2] read as zero. Voice v (0..3) has its phase at bytes 0x10+8v..0x13+8v and its increment at 0x14+8v..0x17+8v, most significant byte first. Only bits [23:0] are stored, so the first byte of each register reads 0 and writes to it are dropped. Every other address reads 0.
- R3: On each cycle where tick is high and the mode is 2, every voice phase becomes (phase + increment) mod 2^24.
- R4: The table index of a voice is bits [23:15] of its freshly advanced phase, not of the phase before the step.
- R5: Voices 0 and 1 read table address equal to the index. Voices 2 and 3 read table address 512 plus the index.
- R6: out_left and out_right both equal the sum of the four looked-up samples shifted right by 2.
- R7: While the mode is not 2 (for example 0 or 1), tick has no effect: the phases keep their values and out_valid stays low.
- R8: out_valid rises in the cycle after an accepted tick and lasts one cycle for a single tick. The sample outputs hold their values between accepted ticks.
- R9: A table write (tbl_we high) stores tbl_wdata at tbl_addr, and any lookup made on a later tick sees the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample strobe |
| reg_we | input | 1 | Register byte write enable |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 10 | Table write address |
| tbl_wdata | input | 8 | Table write data |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 8 | Left output sample |
| out_right | output | 8 | Right output sample |

## Verification
The phase-step assertion only applies when no host write hits a voice register in the same cycle as an accepted tick. The bench therefore keeps register writes and ticks in separate cycles. The bench loads the whole table before it enables wavetable mode, so no lookup reads an unwritten entry. Expected samples come from a bench model of the phases and the table. That model is swept across several phase and increment sets, including backward steps that wrap through the top of the 24-bit range.

// File: rtl/qwo_pkg.sv
package qwo_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_STREAM = 2'd1,
    MODE_WAVE   = 2'd2,
    MODE_RSVD   = 2'd3
  } qwo_mode_e;

  localparam int unsigned MODE_ADDR    = 1;
  localparam int unsigned VOICE_BASE   = 16;
  localparam int unsigned VOICE_STRIDE = 8;
  localparam int unsigned REG_BYTES    = 4;
  localparam int unsigned BYTE_W       = 8;
endpackage

// File: rtl/qwo_voice_regs.sv
module qwo_voice_regs #(
  parameter int unsigned PHASE_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               wr_en,
  input  logic [2:0]         byte_sel,
  input  logic [7:0]         wr_data,
  output logic [7:0]         rd_data,
  output logic [PHASE_W-1:0] lookup_phase
);
  localparam int unsigned WIDE_W = qwo_pkg::REG_BYTES * qwo_pkg::BYTE_W;

  logic [PHASE_W-1:0] phase_q, phase_d, inc_q, inc_d, phase_step;
  logic [WIDE_W-1:0]  ph_wide, in_wide, rd_wide;
  logic [1:0]         lane;

  always_comb begin
    phase_step = adv ? (phase_q + inc_q) : phase_q;
    ph_wide    = WIDE_W'(phase_step);
    in_wide    = WIDE_W'(inc_q);
    lane       = 2'd3 - byte_sel[1:0];
    if (wr_en) begin
      if (byte_sel[2]) in_wide[{lane, 3'b000} +: 8] = wr_data;
      else             ph_wide[{lane, 3'b000} +: 8] = wr_data;
    end
    phase_d      = ph_wide[PHASE_W-1:0];
    inc_d        = in_wide[PHASE_W-1:0];
    lookup_phase = phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      inc_q   <= '0;
    end else if (adv || wr_en) begin
      phase_q <= phase_d;
      inc_q   <= inc_d;
    end
  end

  always_comb begin
    rd_wide = byte_sel[2] ? WIDE_W'(inc_q) : WIDE_W'(phase_q);
    rd_data = rd_wide[{2'd3 - byte_sel[1:0], 3'b000} +: 8];
  end

  // R3: an accepted step adds the increment modulo the phase width
  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en) |=> (phase_q == PHASE_W'($past(phase_q) + $past(inc_q))));

  // R7: with no step and no write, voice state is frozen
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !wr_en) |=> ($stable(phase_q) && $stable(inc_q)));
endmodule

// File: rtl/qwo_wave_ram.sv
module qwo_wave_ram #(
  parameter int unsigned AW  = 10,
  parameter int unsigned DW  = 8,
  parameter int unsigned NRD = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [NRD*AW-1:0] rd_addr,
  output logic [NRD*DW-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= wr_data;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r*DW +: DW] = mem[rd_addr[r*AW +: AW]];
  end
endmodule

// File: rtl/qwo_mix.sv
module qwo_mix #(
  parameter int unsigned NV = 4,
  parameter int unsigned DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [NV*DW-1:0] samples,
  output logic             out_valid,
  output logic [DW-1:0]    out_left,
  output logic [DW-1:0]    out_right
);
  localparam int unsigned SH    = $clog2(NV);
  localparam int unsigned SUM_W = DW + SH;

  logic [SUM_W-1:0] sum;
  logic [DW-1:0]    mix;
  logic             valid_q;
  logic [DW-1:0]    left_q, right_q;

  always_comb begin
    sum = '0;
    for (int i = 0; i < int'(NV); i++) sum = sum + SUM_W'(samples[i*DW +: DW]);
    mix = DW'(sum >> SH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
    end else if (adv) begin
      left_q  <= mix;
      right_q <= mix;
    end
  end

  assign out_valid = valid_q;
  assign out_left  = left_q;
  assign out_right = right_q;

  // R8: valid follows an accepted tick by one cycle only
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> out_valid);
  assert_valid_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> !out_valid);
  // R8: outputs hold between accepted ticks
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(out_left) && $stable(out_right)));
  // R6: both channels carry the same mix
  assert_stereo_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_left == out_right));
endmodule

// File: rtl/qwo_top.sv
module qwo_top #(
  parameter int unsigned NUM_VOICES = 4,
  parameter int unsigned PHASE_W    = 24,
  parameter int unsigned FRAC_W     = 15,
  parameter int unsigned SAMPLE_W   = 8,
  parameter int unsigned REG_AW     = 6,
  localparam int unsigned IDX_W     = PHASE_W - FRAC_W,
  localparam int unsigned TBL_AW    = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                reg_we,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic                tbl_we,
  input  logic [TBL_AW-1:0]   tbl_addr,
  input  logic [SAMPLE_W-1:0] tbl_wdata,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);
  import qwo_pkg::*;

  localparam int unsigned PER_HALF = NUM_VOICES / 2;
  localparam int unsigned BLK_W    = REG_AW - 3;
  localparam int unsigned BLK0     = VOICE_BASE / VOICE_STRIDE;
  localparam int unsigned VEND     = VOICE_BASE + VOICE_STRIDE * NUM_VOICES;

  logic [1:0]                   mode_q, mode_d;
  logic                         adv;
  logic [NUM_VOICES-1:0]        hit;
  logic [7:0]                   vrd [NUM_VOICES];
  logic [NUM_VOICES*TBL_AW-1:0] rd_addr;
  logic [NUM_VOICES*SAMPLE_W-1:0] samples;

  // mode register: next state and storage
  always_comb begin
    mode_d = mode_q;
    if (reg_we && (reg_addr == REG_AW'(MODE_ADDR))) mode_d = reg_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 2'(MODE_OFF);
    else        mode_q <= mode_d;
  end

  assign adv = tick && (mode_q == 2'(MODE_WAVE));

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
    localparam logic [BLK_W-1:0] BLK  = BLK_W'(BLK0 + v);
    localparam logic             HALF = 1'(v / PER_HALF);
    logic [PHASE_W-1:0] lph;

    assign hit[v] = (reg_addr[REG_AW-1:3] == BLK);

    qwo_voice_regs #(.PHASE_W(PHASE_W)) u_voice (
      .clk          (clk),
      .rst_n        (rst_n),
      .adv          (adv),
      .wr_en        (reg_we && hit[v]),
      .byte_sel     (reg_addr[2:0]),
      .wr_data      (reg_wdata),
      .rd_data      (vrd[v]),
      .lookup_phase (lph)
    );

    assign rd_addr[v*TBL_AW +: TBL_AW] = {HALF, lph[PHASE_W-1:FRAC_W]};
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == REG_AW'(MODE_ADDR)) reg_rdata = {6'b0, mode_q};
    for (int v = 0; v < int'(NUM_VOICES); v++) begin
      if (hit[v]) reg_rdata = vrd[v];
    end
  end

  qwo_wave_ram #(.AW(TBL_AW), .DW(SAMPLE_W), .NRD(NUM_VOICES)) u_ram (
    .clk     (clk),
    .we      (tbl_we),
    .wr_addr (tbl_addr),
    .wr_data (tbl_wdata),
    .rd_addr (rd_addr),
    .rd_data (samples)
  );

  qwo_mix #(.NV(NUM_VOICES), .DW(SAMPLE_W)) u_mix (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .samples   (samples),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right)
  );

  // R7: no output strobe follows a cycle outside wavetable mode
  assert_mode_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'(MODE_WAVE)) |=> !out_valid);

  // R2: the top byte of every voice register reads zero
  assert_top_byte_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(reg_addr) >= VOICE_BASE) && (32'(reg_addr) < VEND) && (reg_addr[1:0] == 2'b00))
      |-> (reg_rdata == 8'h00));
endmodule

// File: tb/tb_qwo_top.sv
`timescale 1ns/1ps
module tb_qwo_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, reg_we, tbl_we;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, tbl_wdata, out_left, out_right;
  logic [9:0] tbl_addr;
  logic       out_valid;

  int total = 0;
  int bad   = 0;

  logic [7:0]  mdl [1024];
  logic [23:0] mph [4];
  logic [23:0] minc [4];

  always #2.5 clk = ~clk;

  qwo_top dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input int a, output int d);
    @(negedge clk);
    reg_addr = 6'(a);
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic tbl_write(input int a, input int d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 10'(a); tbl_wdata = 8'(d);
    @(negedge clk);
    tbl_we = 1'b0;
    mdl[a] = 8'(d);
  endtask

  task automatic set_voice(input int v, input logic [23:0] ph, input logic [23:0] inc);
    int base;
    base = 16 + 8 * v;
    wr_reg(base + 1, int'(ph[23:16]));
    wr_reg(base + 2, int'(ph[15:8]));
    wr_reg(base + 3, int'(ph[7:0]));
    wr_reg(base + 5, int'(inc[23:16]));
    wr_reg(base + 6, int'(inc[15:8]));
    wr_reg(base + 7, int'(inc[7:0]));
    mph[v] = ph; minc[v] = inc;
  endtask

  task automatic get_phase(input int v, output int ph);
    int b1, b2, b3;
    rd_reg(16 + 8 * v + 1, b1);
    rd_reg(16 + 8 * v + 2, b2);
    rd_reg(16 + 8 * v + 3, b3);
    ph = (b1 << 16) | (b2 << 8) | b3;
  endtask

  task automatic do_tick;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  function automatic int model_step();
    int s;
    logic [9:0] ta;
    s = 0;
    for (int v = 0; v < 4; v++) begin
      mph[v] = mph[v] + minc[v];
      ta = {1'(v >> 1), mph[v][23:15]};
      s += int'(mdl[ta]);
    end
    return s >> 2;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d, e, ph;
    rst_n = 1'b0; tick = 1'b0; reg_we = 1'b0; tbl_we = 1'b0;
    reg_addr = '0; reg_wdata = '0; tbl_addr = '0; tbl_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 left", int'(out_left), 0);
    chk("R1 right", int'(out_right), 0);
    rd_reg(1, d);  chk("R1 mode", d, 0);
    get_phase(2, ph); chk("R1 phase", ph, 0);
    rd_reg(23, d); chk("R1 inc", d, 0);

    // R2 register map
    wr_reg(24, 8'hAA); wr_reg(25, 8'hBB); wr_reg(26, 8'hCC); wr_reg(27, 8'hDD);
    wr_reg(28, 8'h11); wr_reg(29, 8'h22); wr_reg(30, 8'h33); wr_reg(31, 8'h44);
    rd_reg(24, d); chk("R2 phase top byte", d, 0);
    rd_reg(25, d); chk("R2 phase b1", d, 8'hBB);
    rd_reg(26, d); chk("R2 phase b2", d, 8'hCC);
    rd_reg(27, d); chk("R2 phase b3", d, 8'hDD);
    rd_reg(28, d); chk("R2 inc top byte", d, 0);
    rd_reg(29, d); chk("R2 inc b1", d, 8'h22);
    rd_reg(31, d); chk("R2 inc b3", d, 8'h44);
    rd_reg(2, d);  chk("R2 unmapped", d, 0);
    wr_reg(1, 8'hFD);
    rd_reg(1, d);  chk("R2 mode bits", d, 1);

    // table load with a computed pattern (R9 write port)
    for (int a = 0; a < 1024; a++) tbl_write(a, (a * 37 + 11) & 255);

    // R7: mode 1 and mode 0 ignore ticks
    for (int m = 1; m >= 0; m--) begin
      wr_reg(1, m);
      for (int k = 0; k < 3; k++) begin
        do_tick;
        chk("R7 no valid", int'(out_valid), 0);
      end
      get_phase(1, ph); chk("R7 phase frozen", ph, 24'hBBCCDD);
      chk("R7 output unchanged", int'(out_left), 0);
    end

    wr_reg(1, 2);

    // R4: lookup uses the advanced phase
    for (int v = 0; v < 4; v++) set_voice(v, 24'h007FFF, 24'h000001);
    do_tick;
    e = (2 * int'(mdl[1]) + 2 * int'(mdl[513])) >> 2;
    chk("R4 updated-phase lookup", int'(out_left), e);
    chk("R8 valid after tick", int'(out_valid), 1);
    @(negedge clk);
    chk("R8 valid single pulse", int'(out_valid), 0);
    chk("R8 left holds", int'(out_left), e);

    // R5 and R9: halves and table rewrite
    for (int v = 0; v < 4; v++) set_voice(v, 24'h0, 24'h0);
    tbl_write(0, 0); tbl_write(512, 8'hFF);
    do_tick;
    chk("R5 half pinning", int'(out_left), 127);
    tbl_write(0, 8'h40);
    do_tick;
    chk("R9 rewrite seen", int'(out_right), 159);

    // R3/R4/R5/R6 sweep over several phase and increment sets
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int v = 0; v < 4; v++) begin
        logic [23:0] p0, i0;
        p0 = 24'(cfg * 24'h3A5C71 + v * 24'h01F0F3);
        if (cfg == 3) begin
          p0 = 24'hFFFF00 - 24'(v);
          i0 = 24'hFFC000 - 24'(v * 24'h1234);
        end else begin
          i0 = 24'(cfg * 24'h02B3D + v * 24'h0913 + 24'h0100);
        end
        set_voice(v, p0, i0);
      end
      for (int n = 0; n < 300; n++) begin
        do_tick;
        e = model_step();
        chk("R6 left mix", int'(out_left), e);
        chk("R6 right mix", int'(out_right), e);
      end
      for (int v = 0; v < 4; v++) begin
        get_phase(v, ph);
        chk("R3 phase accumulate", ph, int'(mph[v]));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule